// File: doc/BRIEF.md
# Power-stage enable and fault sequencer

This block decides, on every clock, whether the switching power stage of a step-down regulator may run, and in which modulation mode. It merges the hardware enable pin, the voltage-select pin, the two software enable bits and the two mode bits. The voltage-select pin chooses which software enable bit and which mode bit are in force.

It then applies protection. Undervoltage, thermal and qualified overvoltage flags each force the stage off while they are present. A run of consecutive current-limited switching cycles sends the stage into a timed, tri-stated hiccup pause, after which it restarts through soft-start.

The outputs control the stage: run, tri-state, output discharge and forced PWM. The block also drives flat status bits that a register file can pick up. The fault comparators are external and arrive as synchronous digital flags. The switching-cycle boundaries arrive as a one-clock strobe, qualified by a current-limit flag.

Top module: `pwr_stage_sequencer`

## Requirements
- R1: Whenever `en_pin` is sampled low at a clock edge, `run` is low after that edge, whatever the other inputs are.
- R2: With `en_pin` high, the stage is requested on by `sw_en0` alone when `vsel` is 0, and by `sw_en1` alone when `vsel` is 1.
- R3: `fpwm` equals `mode[0]` when `vsel` is 0 and `mode[1]` when `vsel` is 1, in both cases only while `run` is high. Otherwise `fpwm` is 0. A mode bit value of 1 means forced PWM and 0 means automatic PFM/PWM.
- R4: `discharge` is high in the same cycle that `dischg_en` is 1 and the decoded request of R1/R2 is off, and low otherwise.
- R5: An accepted start holds `softstart` and `run` high for exactly `SS_CYCLES` clocks. After that, `pgood` rises and `softstart` falls. `pgood` is high only in regulation.
- R6: The stage trips when `ILIM_TRIP` (default 16) consecutive cycle strobes carry `cyc_ilim` = 1 while it runs. After the edge that samples the last such strobe, `run` is 0 and `hiz` is 1.
- R7: A cycle strobe with `cyc_ilim` = 0 resets the consecutive count, so fewer than `ILIM_TRIP` limited cycles on each side of it do not trip.
- R8: `hiz` stays high for exactly `HICCUP_CYCLES` clocks and is followed by a soft-start. If the request goes off during the pause, the block drops to off at once with `hiz` low, and it stays off.
- R9: While `uvlo_in` or `therm_in` is 1, the stage is held off even with the request on. `stat_uvlo` and `stat_ot` mirror these inputs.
- R10: `ovp_in` acts only after it has been high for `OVP_QUAL` consecutive clocks. From then, `stat_ovp` is 1 and `run` drops one clock later. A shorter pulse has no effect.
- R11: `buck_on` equals `run`. Once all faults clear with the request still on, a new soft-start begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_pin | input | 1 | Hardware enable |
| vsel | input | 1 | Voltage-select pin, picks bank 0 or 1 |
| sw_en0 | input | 1 | Software enable for bank 0 |
| sw_en1 | input | 1 | Software enable for bank 1 |
| mode | input | 2 | Forced-PWM bit per bank (bit 0 for bank 0) |
| dischg_en | input | 1 | Output discharge allowed when disabled |
| uvlo_in | input | 1 | Input undervoltage flag |
| ovp_in | input | 1 | Raw input overvoltage flag |
| therm_in | input | 1 | Thermal shutdown flag |
| cyc_done | input | 1 | One-clock strobe at each switching-cycle end |
| cyc_ilim | input | 1 | Current limit hit in the cycle ending now |
| run | output | 1 | Power stage switching allowed |
| hiz | output | 1 | Power stage tri-stated (hiccup pause) |
| discharge | output | 1 | Output pulldown on |
| fpwm | output | 1 | Forced PWM selected |
| softstart | output | 1 | Soft-start ramp in progress |
| pgood | output | 1 | Regulating after completed soft-start |
| buck_on | output | 1 | Stage enabled status |
| stat_uvlo | output | 1 | Undervoltage status |
| stat_ovp | output | 1 | Qualified overvoltage status |
| stat_ot | output | 1 | Thermal shutdown status |

## Verification
The assertions take for granted that every input is already synchronous to `clk`. They also assume that `cyc_ilim` carries meaning only on a `cyc_done` strobe, and that the fault flags are level signals rather than single-clock pulses. The stimulus drives all inputs on the falling edge. It pulses `cyc_done` for exactly one clock with `cyc_ilim` set alongside it, and holds the random enable, select, mode and discharge settings steady for longer than a full soft-start. Random fault values are never mixed into the random phase: fault flags are raised and lowered only in the directed cases.

// File: rtl/seqr_pkg.sv
package seqr_pkg;
  typedef enum logic [1:0] {
    ST_OFF    = 2'd0,
    ST_RAMP   = 2'd1,
    ST_REG    = 2'd2,
    ST_HICCUP = 2'd3
  } seq_state_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/seqr_enable_decode.sv
module seqr_enable_decode (
  input  logic       en_pin,
  input  logic       vsel,
  input  logic       sw_en0,
  input  logic       sw_en1,
  input  logic [1:0] mode,
  output logic       want_on,
  output logic       fpwm_sel
);
  logic [1:0] sw_bank;
  assign sw_bank  = {sw_en1, sw_en0};
  // the select pin picks one bank of software enable and mode bit
  assign want_on  = en_pin & sw_bank[vsel];
  assign fpwm_sel = mode[vsel];
endmodule

// File: rtl/seqr_glitch_filter.sv
module seqr_glitch_filter #(
  parameter int unsigned QUAL = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic qualified
);
  localparam int unsigned CW = $clog2(QUAL + 1);
  localparam logic [CW-1:0] LAST = CW'(QUAL - 1);

  logic [CW-1:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_len   <= '0;
      qualified <= 1'b0;
    end else if (!raw) begin
      run_len   <= '0;
      qualified <= 1'b0;
    end else if (run_len == LAST) begin
      qualified <= 1'b1;
    end else begin
      run_len   <= run_len + 1'b1;
    end
  end

  assert_ovp_needs_raw_R10: assert property (@(posedge clk) disable iff (!rst_n)
    qualified |-> $past(raw));
  assert_ovp_len_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    run_len <= LAST);
endmodule

// File: rtl/seqr_ilim_tracker.sv
module seqr_ilim_tracker #(
  parameter int unsigned TRIP = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic cyc_done,
  input  logic cyc_hit,
  output logic trip
);
  localparam int unsigned CW = $clog2(TRIP + 1);
  localparam logic [CW-1:0] LAST = CW'(TRIP - 1);

  logic [CW-1:0] streak;

  assign trip = active & cyc_done & cyc_hit & (streak == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      streak <= '0;
    end else if (!active) begin
      streak <= '0;
    end else if (cyc_done) begin
      if (!cyc_hit || streak == LAST) streak <= '0;
      else                           streak <= streak + 1'b1;
    end
  end

  assert_streak_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    streak <= LAST);
  assert_clean_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_done && !cyc_hit) |=> (streak == '0));
endmodule

// File: rtl/seqr_wait_timer.sv
module seqr_wait_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] remain;

  assign expired = (remain == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             remain <= '0;
    else if (load)          remain <= load_val;
    else if (remain != '0)  remain <= remain - 1'b1;
  end

  assert_timer_down_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && $past(remain) != '0) |-> (remain == $past(remain) - 1'b1));
endmodule

// File: rtl/pwr_stage_sequencer.sv
module pwr_stage_sequencer
  import seqr_pkg::*;
#(
  parameter int unsigned SS_CYCLES     = 360,
  parameter int unsigned HICCUP_CYCLES = 425000,
  parameter int unsigned ILIM_TRIP     = 16,
  parameter int unsigned OVP_QUAL      = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_pin,
  input  logic       vsel,
  input  logic       sw_en0,
  input  logic       sw_en1,
  input  logic [1:0] mode,
  input  logic       dischg_en,
  input  logic       uvlo_in,
  input  logic       ovp_in,
  input  logic       therm_in,
  input  logic       cyc_done,
  input  logic       cyc_ilim,
  output logic       run,
  output logic       hiz,
  output logic       discharge,
  output logic       fpwm,
  output logic       softstart,
  output logic       pgood,
  output logic       buck_on,
  output logic       stat_uvlo,
  output logic       stat_ovp,
  output logic       stat_ot
);
  localparam int unsigned TMR_W = $clog2(max2(SS_CYCLES, HICCUP_CYCLES) + 1);
  localparam logic [TMR_W-1:0] SS_LOAD = TMR_W'(SS_CYCLES - 1);
  localparam logic [TMR_W-1:0] HC_LOAD = TMR_W'(HICCUP_CYCLES - 1);

  seq_state_e       state, nxt;
  logic             want_on, fpwm_sel, ovp_q, fault, trip, tmr_done;
  logic             tmr_load;
  logic [TMR_W-1:0] tmr_val;

  seqr_enable_decode u_dec (
    .en_pin   (en_pin),
    .vsel     (vsel),
    .sw_en0   (sw_en0),
    .sw_en1   (sw_en1),
    .mode     (mode),
    .want_on  (want_on),
    .fpwm_sel (fpwm_sel)
  );

  seqr_glitch_filter #(.QUAL(OVP_QUAL)) u_ovp (
    .clk       (clk),
    .rst_n     (rst_n),
    .raw       (ovp_in),
    .qualified (ovp_q)
  );

  seqr_ilim_tracker #(.TRIP(ILIM_TRIP)) u_ilim (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (run),
    .cyc_done (cyc_done),
    .cyc_hit  (cyc_ilim),
    .trip     (trip)
  );

  seqr_wait_timer #(.W(TMR_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_done)
  );

  assign fault = uvlo_in | therm_in | ovp_q;

  always_comb begin
    nxt      = state;
    tmr_load = 1'b0;
    tmr_val  = SS_LOAD;
    unique case (state)
      ST_OFF: begin
        if (want_on && !fault) begin
          nxt      = ST_RAMP;
          tmr_load = 1'b1;
        end
      end
      ST_RAMP, ST_REG: begin
        if (!want_on || fault) begin
          nxt = ST_OFF;
        end else if (trip) begin
          nxt      = ST_HICCUP;
          tmr_load = 1'b1;
          tmr_val  = HC_LOAD;
        end else if (state == ST_RAMP && tmr_done) begin
          nxt = ST_REG;
        end
      end
      ST_HICCUP: begin
        if (!want_on) begin
          nxt = ST_OFF;
        end else if (tmr_done) begin
          if (fault) begin
            nxt = ST_OFF;
          end else begin
            nxt      = ST_RAMP;
            tmr_load = 1'b1;
          end
        end
      end
      default: nxt = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_OFF;
    else        state <= nxt;
  end

  assign run       = (state == ST_RAMP) || (state == ST_REG);
  assign hiz       = (state == ST_HICCUP);
  assign softstart = (state == ST_RAMP);
  assign pgood     = (state == ST_REG);
  assign buck_on   = run;
  assign fpwm      = run & fpwm_sel;
  assign discharge = dischg_en & ~want_on;
  assign stat_uvlo = uvlo_in;
  assign stat_ot   = therm_in;
  assign stat_ovp  = ovp_q;

  assert_en_low_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en_pin |=> !run);
  assert_discharge_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    discharge |=> !run);
  assert_pgood_after_ramp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pgood) |-> $past(softstart));
  assert_hiz_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hiz) |-> $past(cyc_done && cyc_ilim));
  assert_fault_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (uvlo_in || therm_in) |=> !run);
  assert_ovp_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stat_ovp |=> !run);
endmodule

// File: tb/tb_pwr_stage_sequencer.sv
module tb_pwr_stage_sequencer;
  localparam int SS  = 12;
  localparam int HC  = 40;
  localparam int TRP = 16;
  localparam int OVQ = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_pin = 0, vsel = 0, sw_en0 = 0, sw_en1 = 0, dischg_en = 0;
  logic [1:0] mode = 2'b00;
  logic uvlo_in = 0, ovp_in = 0, therm_in = 0, cyc_done = 0, cyc_ilim = 0;
  logic run, hiz, discharge, fpwm, softstart, pgood, buck_on, stat_uvlo, stat_ovp, stat_ot;
  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  pwr_stage_sequencer #(.SS_CYCLES(SS), .HICCUP_CYCLES(HC), .ILIM_TRIP(TRP), .OVP_QUAL(OVQ)) dut (
    .clk(clk), .rst_n(rst_n), .en_pin(en_pin), .vsel(vsel), .sw_en0(sw_en0), .sw_en1(sw_en1),
    .mode(mode), .dischg_en(dischg_en), .uvlo_in(uvlo_in), .ovp_in(ovp_in), .therm_in(therm_in),
    .cyc_done(cyc_done), .cyc_ilim(cyc_ilim), .run(run), .hiz(hiz), .discharge(discharge),
    .fpwm(fpwm), .softstart(softstart), .pgood(pgood), .buck_on(buck_on),
    .stat_uvlo(stat_uvlo), .stat_ovp(stat_ovp), .stat_ot(stat_ot));

  function automatic logic exp_on(input logic e, input logic v, input logic s0, input logic s1);
    return e && (v ? s1 : s0);
  endfunction

  function automatic logic exp_fpwm(input logic v, input logic [1:0] m, input logic on);
    return on && (v ? m[1] : m[0]);
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic limit_cycle(input logic hit);
    cyc_done = 1'b1;
    cyc_ilim = hit;
    @(negedge clk);
    cyc_done = 1'b0;
    cyc_ilim = 1'b0;
  endtask

  task automatic hits(input int n);
    for (int i = 0; i < n; i++) limit_cycle(1'b1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1729));
    step(3);
    rst_n = 1'b1;
    step(1);
    chk("R5", "reset run", run, 0);
    chk("R6", "reset hiz", hiz, 0);
    chk("R5", "reset pgood", pgood, 0);
    chk("R11", "reset buck_on", buck_on, 0);

    // start on bank 0, auto mode
    en_pin = 1; vsel = 0; sw_en0 = 1; sw_en1 = 0; mode = 2'b10; dischg_en = 1;
    #1 chk("R4", "discharge while requested", discharge, 0);
    step(1);
    chk("R5", "ramp starts", softstart, 1);
    chk("R11", "buck_on in ramp", buck_on, 1);
    step(SS - 1);
    chk("R5", "ramp last clock", softstart, 1);
    chk("R5", "no pgood in ramp", pgood, 0);
    step(1);
    chk("R5", "pgood after ramp", pgood, 1);
    chk("R5", "ramp ended", softstart, 0);
    chk("R3", "bank0 auto", fpwm, 0);

    // switch to bank 1 with its enable clear
    vsel = 1;
    #1 chk("R4", "discharge on bank1 off", discharge, 1);
    step(1);
    chk("R2", "bank1 disabled", run, 0);
    chk("R3", "fpwm when stopped", fpwm, 0);
    sw_en1 = 1;
    step(SS + 1);
    chk("R2", "bank1 enabled", pgood, 1);
    chk("R3", "bank1 forced", fpwm, 1);

    en_pin = 0;
    step(1);
    chk("R1", "en low stops", run, 0);
    chk("R4", "discharge en low", discharge, 1);
    en_pin = 1;
    step(SS + 1);
    chk("R5", "regulating again", pgood, 1);

    // current limit streak broken by a clean cycle
    hits(TRP - 1); limit_cycle(1'b0); hits(TRP - 1);
    chk("R7", "no trip across clean cycle", hiz, 0);
    chk("R7", "still running", run, 1);
    limit_cycle(1'b0);
    hits(TRP - 1);
    chk("R6", "one short of trip", hiz, 0);
    hits(1);
    chk("R6", "tripped hiz", hiz, 1);
    chk("R6", "tripped run", run, 0);
    step(HC - 1);
    chk("R8", "pause last clock", hiz, 1);
    step(1);
    chk("R8", "restart ramp", softstart, 1);
    chk("R8", "hiz released", hiz, 0);
    step(SS);
    chk("R8", "regulating after pause", pgood, 1);

    // enable lost during pause
    hits(TRP);
    step(3);
    en_pin = 0;
    step(1);
    chk("R8", "off from pause hiz", hiz, 0);
    chk("R8", "off from pause run", run, 0);
    step(HC + 5);
    chk("R8", "stays off", run, 0);
    en_pin = 1;
    step(SS + 1);
    chk("R8", "back on", pgood, 1);

    // overvoltage filter
    ovp_in = 1; step(OVQ - 1); ovp_in = 0;
    step(3);
    chk("R10", "glitch ignored", pgood, 1);
    chk("R10", "glitch no status", stat_ovp, 0);
    ovp_in = 1;
    step(OVQ);
    chk("R10", "qualified status", stat_ovp, 1);
    chk("R10", "run one clock more", run, 1);
    step(1);
    chk("R10", "ovp stops", run, 0);
    ovp_in = 0;
    step(2);
    chk("R11", "restart after ovp", softstart, 1);
    step(SS);
    chk("R11", "pgood after ovp", pgood, 1);

    // undervoltage
    uvlo_in = 1;
    step(1);
    chk("R9", "uvlo stops", run, 0);
    chk("R9", "uvlo status", stat_uvlo, 1);
    step(5);
    chk("R9", "uvlo holds off", run, 0);
    uvlo_in = 0;
    step(1);
    chk("R11", "restart after uvlo", softstart, 1);
    step(SS);

    // thermal
    therm_in = 1;
    step(1);
    chk("R9", "thermal stops", run, 0);
    chk("R9", "thermal status", stat_ot, 1);
    step(4);
    chk("R9", "thermal holds off", buck_on, 0);
    therm_in = 0;
    step(SS + 2);
    chk("R11", "pgood after thermal", pgood, 1);

    // random enable, select and mode settings
    for (int it = 0; it < 40; it++) begin
      logic on;
      en_pin = $urandom % 4 != 0; vsel = $urandom % 2;
      sw_en0 = $urandom % 2; sw_en1 = $urandom % 2;
      mode = 2'($urandom % 4); dischg_en = $urandom % 2;
      on = exp_on(en_pin, vsel, sw_en0, sw_en1);
      #1 chk("R4", "random discharge", discharge, dischg_en && !on);
      step(SS + 3);
      chk("R2", "random run", run, on);
      chk("R5", "random pgood", pgood, on);
      chk("R3", "random fpwm", fpwm, exp_fpwm(vsel, mode, on));
      chk("R1", "random buck_on", buck_on, on);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule